// File: doc/BRIEF.md
# AXI Outstanding Transaction Limiter

This block sits on the read and write address channels between an AXI manager and its subordinate. It keeps a count of reads whose last data beat has not yet returned and of writes whose response has not yet returned. When accepting one more address would break a configured cap, it closes that address channel. Three caps apply at once: pending reads, pending writes, and the sum of both. A cap of zero disables that cap.

The address channels use a simplified valid/ready handshake. While a channel is open, valid and ready pass straight through. While it is closed, both directions are forced low, so neither side sees a handshake. Completions arrive as strobes: a read-data handshake qualified by its last flag, and a write-response handshake. The caps are static inputs and are changed only while reset is held.

Top module: `axi_pending_limiter`

## Requirements
- R1: After reset both pending counts read 0 and the error flag is 0.
- R2: The read count rises by one on each accepted read address and falls by one on each read-data strobe with the last flag set. Both events in one cycle leave the count unchanged. A data strobe without the last flag has no effect.
- R3: The write count rises by one on each accepted write address and falls by one on each write-response strobe. Both events in one cycle leave the count unchanged.
- R4: With a nonzero read cap, the read address channel is closed while the read count is at or above the cap. A read cap of 0 never closes the channel.
- R5: With a nonzero write cap, the write address channel is closed while the write count is at or above the cap. A write cap of 0 never closes the channel.
- R6: With a nonzero combined cap, no address is accepted that would make the read count plus the write count exceed the cap. A combined cap of 0 never closes either channel.
- R7: When one combined slot is left and both channels would otherwise accept in the same cycle, the read is accepted and the write is held back for that cycle.
- R8: The decision to open a channel uses the counts held at the start of the cycle. A completion in the same cycle frees its slot only from the next cycle on.
- R9: A completion that arrives while its count is 0 leaves the count at 0 and sets the error flag. The flag stays set until reset.
- R10: While a channel is open, the subordinate-side valid equals the manager's valid and the manager-side ready equals the subordinate's ready. While it is closed, both are 0.
- R11: A count that has reached its all-ones maximum (255 with the default 8-bit counters) closes its channel even when every cap is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rd_max | input | LIM_W | Read cap, 0 = no cap |
| cfg_wr_max | input | LIM_W | Write cap, 0 = no cap |
| cfg_tot_max | input | LIM_W | Combined cap, 0 = no cap |
| m_ar_valid | input | 1 | Read address valid from the manager |
| m_ar_ready | output | 1 | Read address ready to the manager |
| s_ar_valid | output | 1 | Read address valid to the subordinate |
| s_ar_ready | input | 1 | Read address ready from the subordinate |
| m_aw_valid | input | 1 | Write address valid from the manager |
| m_aw_ready | output | 1 | Write address ready to the manager |
| s_aw_valid | output | 1 | Write address valid to the subordinate |
| s_aw_ready | input | 1 | Write address ready from the subordinate |
| r_fire | input | 1 | Read-data handshake strobe |
| r_last | input | 1 | Last-beat flag for r_fire |
| b_fire | input | 1 | Write-response handshake strobe |
| rd_pending | output | CNT_W | Reads in flight |
| wr_pending | output | CNT_W | Writes in flight |
| err_underflow | output | 1 | Sticky flag for a completion with nothing pending |

## Verification
The cap assertions assume that the caps do not change outside reset. A cap lowered below the live count would break them even though the design behaves correctly. The bench loads each cap configuration only while reset is held. The underflow check is the one place where completions are deliberately sent with nothing pending, and the assertions on counter steps still hold in that case because the count stays at 0. The sweep covers every read, write and combined cap from 0 to 3, 0 to 3 and 0 to 5. Its expected counts are the minimum of the active caps and the number of attempts.

// File: rtl/axi_pending_limiter.sv
module axi_pending_limiter #(
  parameter int LIM_W = 6,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LIM_W-1:0] cfg_rd_max,
  input  logic [LIM_W-1:0] cfg_wr_max,
  input  logic [LIM_W-1:0] cfg_tot_max,
  input  logic             m_ar_valid,
  output logic             m_ar_ready,
  output logic             s_ar_valid,
  input  logic             s_ar_ready,
  input  logic             m_aw_valid,
  output logic             m_aw_ready,
  output logic             s_aw_valid,
  input  logic             s_aw_ready,
  input  logic             r_fire,
  input  logic             r_last,
  input  logic             b_fire,
  output logic [CNT_W-1:0] rd_pending,
  output logic [CNT_W-1:0] wr_pending,
  output logic             err_underflow
);
  localparam int SUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] rd_q, wr_q;
  logic             err_q;
  logic [SUM_W-1:0] tot;
  logic             ar_open, aw_open, ar_hs, aw_hs;
  logic             rd_done, rd_under, wr_under;

  assign tot = SUM_W'(rd_q) + SUM_W'(wr_q);

  assign ar_open = (rd_q != CNT_TOP)
                && (cfg_rd_max == '0 || rd_q < CNT_W'(cfg_rd_max))
                && (cfg_tot_max == '0 || tot < SUM_W'(cfg_tot_max));
  assign ar_hs = m_ar_valid && s_ar_ready && ar_open;

  assign aw_open = (wr_q != CNT_TOP)
                && (cfg_wr_max == '0 || wr_q < CNT_W'(cfg_wr_max))
                && (cfg_tot_max == '0 || (tot + SUM_W'(ar_hs)) < SUM_W'(cfg_tot_max));
  assign aw_hs = m_aw_valid && s_aw_ready && aw_open;

  assign s_ar_valid = m_ar_valid && ar_open;
  assign m_ar_ready = s_ar_ready && ar_open;
  assign s_aw_valid = m_aw_valid && aw_open;
  assign m_aw_ready = s_aw_ready && aw_open;

  assign rd_done  = r_fire && r_last;
  assign rd_under = rd_done && rd_q == '0;
  assign wr_under = b_fire && wr_q == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      err_q <= 1'b0;
    end else begin
      rd_q  <= rd_q + CNT_W'(ar_hs) - CNT_W'(rd_done && !rd_under);
      wr_q  <= wr_q + CNT_W'(aw_hs) - CNT_W'(b_fire && !wr_under);
      err_q <= err_q || rd_under || wr_under;
    end
  end

  assign rd_pending    = rd_q;
  assign wr_pending    = wr_q;
  assign err_underflow = err_q;
endmodule

// File: rtl/limiter_checks.sv
module limiter_checks #(
  parameter int LIM_W = 6,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LIM_W-1:0] cfg_rd_max,
  input logic [LIM_W-1:0] cfg_wr_max,
  input logic [LIM_W-1:0] cfg_tot_max,
  input logic             m_ar_valid,
  input logic             m_ar_ready,
  input logic             s_ar_valid,
  input logic             m_aw_valid,
  input logic             m_aw_ready,
  input logic             s_aw_valid,
  input logic             r_fire,
  input logic             r_last,
  input logic             b_fire,
  input logic [CNT_W-1:0] rd_pending,
  input logic [CNT_W-1:0] wr_pending,
  input logic             err_underflow
);
  logic [CNT_W:0] tot;
  assign tot = (CNT_W+1)'(rd_pending) + (CNT_W+1)'(wr_pending);

  AST_RD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_max != '0 |-> rd_pending <= CNT_W'(cfg_rd_max));  // R4
  AST_WR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_max != '0 |-> wr_pending <= CNT_W'(cfg_wr_max));  // R5
  AST_TOT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_tot_max != '0 |-> tot <= (CNT_W+1)'(cfg_tot_max));  // R6
  AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ar_valid && m_ar_ready && m_aw_valid && m_aw_ready && cfg_tot_max != '0)
      |-> tot + 2 <= (CNT_W+1)'(cfg_tot_max));  // R7
  AST_AR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ar_valid && m_ar_ready) |-> s_ar_valid);  // R10
  AST_AW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_aw_valid && m_aw_ready) |-> s_aw_valid);  // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |=> err_underflow);  // R9
  AST_RD_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
    (r_fire && r_last && rd_pending == '0) |=> err_underflow);  // R9
  AST_WR_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
    (b_fire && wr_pending == '0) |=> err_underflow);  // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(m_ar_valid && m_ar_ready) && !(r_fire && r_last)) |=> $stable(rd_pending));  // R2
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(m_aw_valid && m_aw_ready) && !b_fire) |=> $stable(wr_pending));  // R3
endmodule

bind axi_pending_limiter limiter_checks #(.LIM_W(LIM_W), .CNT_W(CNT_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .cfg_rd_max(cfg_rd_max), .cfg_wr_max(cfg_wr_max),
  .cfg_tot_max(cfg_tot_max), .m_ar_valid(m_ar_valid), .m_ar_ready(m_ar_ready),
  .s_ar_valid(s_ar_valid), .m_aw_valid(m_aw_valid), .m_aw_ready(m_aw_ready),
  .s_aw_valid(s_aw_valid), .r_fire(r_fire), .r_last(r_last), .b_fire(b_fire),
  .rd_pending(rd_pending), .wr_pending(wr_pending), .err_underflow(err_underflow)
);

// File: tb/test_axi_pending_limiter.sv
module test_axi_pending_limiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] cfg_rd_max = '0, cfg_wr_max = '0, cfg_tot_max = '0;
  logic m_ar_valid = 0, s_ar_ready = 0, m_aw_valid = 0, s_aw_ready = 0;
  logic r_fire = 0, r_last = 0, b_fire = 0;
  logic m_ar_ready, s_ar_valid, m_aw_ready, s_aw_valid, err_underflow;
  logic [7:0] rd_pending, wr_pending;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  axi_pending_limiter i_axi_pending_limiter (
    .clk(clk), .rst_n(rst_n), .cfg_rd_max(cfg_rd_max), .cfg_wr_max(cfg_wr_max),
    .cfg_tot_max(cfg_tot_max), .m_ar_valid(m_ar_valid), .m_ar_ready(m_ar_ready),
    .s_ar_valid(s_ar_valid), .s_ar_ready(s_ar_ready), .m_aw_valid(m_aw_valid),
    .m_aw_ready(m_aw_ready), .s_aw_valid(s_aw_valid), .s_aw_ready(s_aw_ready),
    .r_fire(r_fire), .r_last(r_last), .b_fire(b_fire), .rd_pending(rd_pending),
    .wr_pending(wr_pending), .err_underflow(err_underflow));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int rl, input int wl, input int tl);
    @(negedge clk);
    rst_n = 0; cfg_rd_max = 6'(rl); cfg_wr_max = 6'(wl); cfg_tot_max = 6'(tl);
    m_ar_valid = 0; m_aw_valid = 0; s_ar_ready = 0; s_aw_ready = 0;
    r_fire = 0; r_last = 0; b_fire = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic issue_rd(input int n, output int acc);
    acc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); m_ar_valid = 1; s_ar_ready = 1;
      #1 if (m_ar_ready) acc++;
    end
    @(negedge clk); m_ar_valid = 0; s_ar_ready = 0;
  endtask

  task automatic issue_wr(input int n, output int acc);
    acc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); m_aw_valid = 1; s_aw_ready = 1;
      #1 if (m_aw_ready) acc++;
    end
    @(negedge clk); m_aw_valid = 0; s_aw_ready = 0;
  endtask

  function automatic int lim(input int v);
    return (v == 0) ? 1000 : v;
  endfunction

  function automatic int min3(input int a, input int b, input int c);
    int m = a;
    if (b < m) m = b;
    if (c < m) m = c;
    return m;
  endfunction

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int acc, acc_w, exp_r, exp_w;
    do_reset(0, 0, 0);
    @(negedge clk);
    check("R1 rd_pending", rd_pending, 0);
    check("R1 wr_pending", wr_pending, 0);
    check("R1 err", err_underflow, 0);

    // R4 R5 R6 sweep
    for (int rl = 0; rl < 4; rl++)
      for (int wl = 0; wl < 4; wl++)
        for (int tl = 0; tl < 6; tl++) begin
          do_reset(rl, wl, tl);
          issue_rd(8, acc);
          exp_r = min3(lim(rl), lim(tl), 8);
          check("R4_R6 reads accepted", acc, exp_r);
          check("R2 rd_pending", rd_pending, exp_r);
          issue_wr(8, acc_w);
          exp_w = min3(lim(wl), (tl == 0) ? 1000 : tl - exp_r, 8);
          check("R5_R6 writes accepted", acc_w, exp_w);
          check("R3 wr_pending", wr_pending, exp_w);
          for (int i = 0; i < exp_r; i++) begin
            @(negedge clk); r_fire = 1; r_last = 1;
          end
          for (int i = 0; i < exp_w; i++) begin
            @(negedge clk); r_fire = 0; r_last = 0; b_fire = 1;
          end
          @(negedge clk); r_fire = 0; r_last = 0; b_fire = 0;
          @(negedge clk);
          check("R2 drained", rd_pending, 0);
          check("R3 drained", wr_pending, 0);
          check("R9 no false error", err_underflow, 0);
        end

    // R7 read priority on last combined slot
    do_reset(0, 0, 3);
    issue_rd(1, acc); issue_wr(1, acc);
    @(negedge clk); m_ar_valid = 1; s_ar_ready = 1; m_aw_valid = 1; s_aw_ready = 1;
    #1 check("R7 read granted", m_ar_ready, 1);
    check("R7 write held", m_aw_ready, 0);
    @(negedge clk); m_ar_valid = 0; s_ar_ready = 0; m_aw_valid = 0; s_aw_ready = 0;
    check("R7 rd_pending", rd_pending, 2);
    check("R7 wr_pending", wr_pending, 1);

    // R8 completion frees slot only next cycle
    do_reset(1, 0, 0);
    issue_rd(1, acc);
    @(negedge clk); m_ar_valid = 1; s_ar_ready = 1; r_fire = 1; r_last = 1;
    #1 check("R8 closed during completion", m_ar_ready, 0);
    @(negedge clk); r_fire = 0; r_last = 0;
    #1 check("R8 open next cycle", m_ar_ready, 1);
    @(negedge clk); m_ar_valid = 0; s_ar_ready = 0;
    check("R8 rd_pending", rd_pending, 1);

    // R2 net zero and non-last beat
    do_reset(0, 0, 0);
    issue_rd(2, acc);
    @(negedge clk); m_ar_valid = 1; s_ar_ready = 1; r_fire = 1; r_last = 1;
    @(negedge clk); m_ar_valid = 0; s_ar_ready = 0; r_last = 0;
    @(negedge clk); r_fire = 0;
    check("R2 net zero and non-last", rd_pending, 2);
    // R3 net zero
    issue_wr(1, acc);
    @(negedge clk); m_aw_valid = 1; s_aw_ready = 1; b_fire = 1;
    @(negedge clk); m_aw_valid = 0; s_aw_ready = 0; b_fire = 0;
    check("R3 net zero", wr_pending, 1);

    // R10 pass-through
    do_reset(1, 0, 0);
    @(negedge clk); m_ar_valid = 1; s_ar_ready = 0;
    #1 check("R10 valid passes", s_ar_valid, 1);
    check("R10 ready passes", m_ar_ready, 0);
    s_ar_ready = 1;
    @(negedge clk); s_ar_ready = 1;
    #1 check("R10 closed valid", s_ar_valid, 0);
    check("R10 closed ready", m_ar_ready, 0);
    m_aw_valid = 1; s_aw_ready = 0;
    #1 check("R10 aw valid passes", s_aw_valid, 1);
    @(negedge clk); m_ar_valid = 0; s_ar_ready = 0; m_aw_valid = 0;

    // R9 underflow
    do_reset(0, 0, 0);
    @(negedge clk); b_fire = 1;
    @(negedge clk); b_fire = 0;
    check("R9 wr stays 0", wr_pending, 0);
    check("R9 err set", err_underflow, 1);
    @(negedge clk); r_fire = 1; r_last = 1;
    @(negedge clk); r_fire = 0; r_last = 0;
    repeat (3) @(negedge clk);
    check("R9 rd stays 0", rd_pending, 0);
    check("R9 err sticky", err_underflow, 1);
    do_reset(0, 0, 0);
    @(negedge clk);
    check("R1 err cleared by reset", err_underflow, 0);

    // R11 saturation with no caps
    do_reset(0, 0, 0);
    issue_rd(300, acc);
    check("R11 accepted", acc, 255);
    check("R11 rd_pending", rd_pending, 255);
    @(negedge clk); m_ar_valid = 1; s_ar_ready = 1;
    #1 check("R11 closed", m_ar_ready, 0);
    @(negedge clk); m_ar_valid = 0; s_ar_ready = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule